// File: doc/BRIEF.md
# Real-Time Periodic Interrupt Divider

This block produces a periodic interrupt from the oscillator clock. An 8-bit control register sets the period. A 3-bit prescale code selects a power-of-two stage of 2^(code+9) oscillator cycles. A 4-bit modulus value N divides that stage again by N+1. When the total count has elapsed, a sticky flag is set. The flag drives the interrupt request through an enable mask, and software clears it by writing a one to it.

Writing the control register always restarts both counters from zero, even when the written value equals the one already held. Prescale code 0 parks the counters, and no flag is raised in that case. A two-state sequencer manages the counters:
- `ST_OFF`: the counters are idle.
- `ST_RUN`: the counters advance.

It has four transitions, and each is taken on a control write or in a cycle without one:
- `T_START`: `ST_OFF` to `ST_RUN`, on a control write with a nonzero code.
- `T_STOP`: `ST_RUN` to `ST_OFF`, on a control write with code 0.
- `T_RESTART`: `ST_RUN` to `ST_RUN`, on a control write with a nonzero code.
- `T_HOLD`: no control write, so the state is kept.

Top module: `rti_timer`

## Requirements
- R1: The control register is at address 0x3B and is read and written at any time. Its code field is bits [6:4] and its modulus field is bits [3:0]. Bit 7 always reads 0 and ignores writes.
- R2: For a nonzero code and modulus N, the flag sets (N+1)·2^(code+9) clock cycles after the control write that started counting.
- R3: With code 0, the flag never sets, whatever N holds.
- R4: The flag is bit 0 at address 0x37. Writing that address with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R5: Every control write restarts the full period from zero, including a write of the value already held.
- R6: The enable is bit 0 at address 0x38. `irq` equals flag AND enable. The flag still sets while the enable is 0.
- R7: Reset clears the control register, the enable, the flag and both counters. All three registers read 0 after reset.
- R8: When a period ends in the same cycle as a clear write, the flag ends up set.
- R9: Counting continues after each flag event, so the next event follows one full period later, with no control write needed.
- R10: Reads of any other address return 0. The unused upper bits of the flag and enable registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; clocks the counters and the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request: flag masked by the enable |

## Verification
The bench measures the exact period for several (code, N) pairs, including N=0, N=15 and the longest prescale. An off-by-one in either counter, or a wrong prescale mask, would shift the first rising edge of `irq` by whole cycles or whole stages. It rewrites the same control value in the middle of a period, where a design that restarts only on a changed value would fire early. It holds code 0 with a nonzero N, where a design that lets the modulus counter run would raise the flag. It also lands a clear write exactly on the terminal cycle, where a clear-priority flag would lose the event, and it leaves the enable at 0 while a period ends, where a design that gates the flag itself would lose the pending event.

// File: rtl/rti_pkg.sv
package rti_pkg;

    // Sequencer states
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } rti_state_e;

    // Names of the sequencer transitions, used for visibility only
    typedef enum logic [1:0] {
        T_HOLD    = 2'd0,
        T_START   = 2'd1,
        T_STOP    = 2'd2,
        T_RESTART = 2'd3
    } rti_trans_e;

endpackage

// File: rtl/rti_regs.sv
module rti_regs #(
    parameter int ADDR_W   = 6,
    parameter int CODE_W   = 3,
    parameter int MOD_W    = 4,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLG_ADDR = 6'h37,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 6'h38,
    localparam int DATA_W  = 1 + CODE_W + MOD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ctl_wr,
    output logic [CODE_W-1:0] new_code,
    output logic [CODE_W-1:0] code,
    output logic [MOD_W-1:0]  limit,
    output logic              flag,
    output logic              en
);

    localparam int CTL_W = CODE_W + MOD_W;

    logic [CTL_W-1:0] ctl_q;
    logic             flag_q;
    logic             en_q;
    logic             flg_wr;
    logic             en_wr;

    always_comb begin
        ctl_wr   = we && (addr == CTL_ADDR);
        flg_wr   = we && (addr == FLG_ADDR);
        en_wr    = we && (addr == EN_ADDR);
        new_code = wdata[CTL_W-1:MOD_W];
    end

    // Control register: the top bit is reserved and is not stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= wdata[0];
        end
    end

    // Flag: a period end outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (flg_wr && wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (1'b1)
            (addr == CTL_ADDR): rdata = {1'b0, ctl_q};
            (addr == FLG_ADDR): rdata = {{(DATA_W-1){1'b0}}, flag_q};
            (addr == EN_ADDR):  rdata = {{(DATA_W-1){1'b0}}, en_q};
            default:            rdata = '0;
        endcase
    end

    always_comb begin
        code  = ctl_q[CTL_W-1:MOD_W];
        limit = ctl_q[MOD_W-1:0];
        flag  = flag_q;
        en    = en_q;
    end

endmodule

// File: rtl/rti_seq.sv
module rti_seq
    import rti_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CODE_W-1:0] new_code,
    output logic              run,
    output logic              clr,
    output rti_trans_e        trans
);

    rti_state_e state_q;
    rti_state_e state_d;

    // Next-state and transition decode
    always_comb begin
        state_d = state_q;
        trans   = T_HOLD;
        unique case (state_q)
            ST_OFF: begin
                if (ctl_wr && (new_code != '0)) begin
                    state_d = ST_RUN;
                    trans   = T_START;
                end
            end
            ST_RUN: begin
                if (ctl_wr && (new_code == '0)) begin
                    state_d = ST_OFF;
                    trans   = T_STOP;
                end else if (ctl_wr) begin
                    state_d = ST_RUN;
                    trans   = T_RESTART;
                end
            end
            default: begin
                state_d = ST_OFF;
                trans   = T_HOLD;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        run = 1'b0;
        clr = ctl_wr;
        unique case (state_q)
            ST_OFF:  run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler #(
    parameter int CODE_W   = 3,
    parameter int LOG_BASE = 9,
    localparam int N_CODES = 1 << CODE_W,
    localparam int PRE_W   = LOG_BASE + N_CODES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick,
    output logic [PRE_W-1:0]  cnt
);

    logic [PRE_W-1:0] term_tab [N_CODES];
    logic [PRE_W-1:0] cnt_q;
    logic             at_term;

    // Terminal value for each code: 2^(code+LOG_BASE) - 1
    for (genvar g = 0; g < N_CODES; g++) begin : g_term
        if (g == 0) begin : g_off
            assign term_tab[g] = '0;
        end else begin : g_on
            localparam logic [PRE_W:0] SPAN = (PRE_W+1)'(1) << (LOG_BASE + g);
            assign term_tab[g] = PRE_W'(SPAN - 1'b1);
        end
    end

    always_comb begin
        at_term = (cnt_q == term_tab[code]);
        tick    = run && at_term;
        cnt     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_term ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rti_modulus.sv
module rti_modulus #(
    parameter int MOD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [MOD_W-1:0] limit,
    output logic             done,
    output logic [MOD_W-1:0] cnt
);

    logic [MOD_W-1:0] cnt_q;
    logic             at_limit;

    always_comb begin
        at_limit = (cnt_q == limit);
        done     = tick && at_limit;
        cnt      = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rti_timer.sv
module rti_timer
    import rti_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int CODE_W   = 3,
    parameter int MOD_W    = 4,
    parameter int LOG_BASE = 9,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLG_ADDR = 6'h37,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 6'h38,
    localparam int DATA_W  = 1 + CODE_W + MOD_W,
    localparam int PRE_W   = LOG_BASE + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              ctl_wr;
    logic [CODE_W-1:0] new_code;
    logic [CODE_W-1:0] code;
    logic [MOD_W-1:0]  limit;
    logic              flag;
    logic              en;
    logic              run;
    logic              clr;
    logic              tick;
    logic              done;
    logic [PRE_W-1:0]  pre_cnt;
    logic [MOD_W-1:0]  mod_cnt;
    rti_trans_e        trans;

    rti_regs #(
        .ADDR_W   (ADDR_W),
        .CODE_W   (CODE_W),
        .MOD_W    (MOD_W),
        .CTL_ADDR (CTL_ADDR),
        .FLG_ADDR (FLG_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .done     (done),
        .rdata    (bus_rdata),
        .ctl_wr   (ctl_wr),
        .new_code (new_code),
        .code     (code),
        .limit    (limit),
        .flag     (flag),
        .en       (en)
    );

    rti_seq #(
        .CODE_W (CODE_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .new_code (new_code),
        .run      (run),
        .clr      (clr),
        .trans    (trans)
    );

    rti_prescaler #(
        .CODE_W   (CODE_W),
        .LOG_BASE (LOG_BASE)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .code  (code),
        .tick  (tick),
        .cnt   (pre_cnt)
    );

    rti_modulus #(
        .MOD_W (MOD_W)
    ) mod_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .limit (limit),
        .done  (done),
        .cnt   (mod_cnt)
    );

    always_comb begin
        irq = flag && en;
    end

endmodule

// File: rtl/rti_chk.sv
module rti_chk #(
    parameter int ADDR_W = 6,
    parameter int CODE_W = 3,
    parameter int MOD_W  = 4,
    parameter int PRE_W  = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLG_ADDR = 6'h37
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              ctl_wr,
    input logic [CODE_W-1:0] code,
    input logic [MOD_W-1:0]  limit,
    input logic              run,
    input logic              done,
    input logic              flag,
    input logic              en,
    input logic              irq,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [MOD_W-1:0]  mod_cnt
);

    p_bit7_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTL_ADDR) |-> !rdata[DATA_W-1]);

    p_done_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    p_mod_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mod_cnt <= limit);

    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> !done);

    p_run_tracks_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run == (code != '0));

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == FLG_ADDR) && wdata[0] && !done) |=> !flag);

    p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ((pre_cnt == '0) && (mod_cnt == '0)));

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && we && (addr == FLG_ADDR) && wdata[0]) |=> flag);

endmodule

bind rti_timer rti_chk #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .MOD_W    (MOD_W),
    .PRE_W    (PRE_W),
    .DATA_W   (DATA_W),
    .CTL_ADDR (CTL_ADDR),
    .FLG_ADDR (FLG_ADDR)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .ctl_wr  (ctl_wr),
    .code    (code),
    .limit   (limit),
    .run     (run),
    .done    (done),
    .flag    (flag),
    .en      (en),
    .irq     (irq),
    .pre_cnt (pre_cnt),
    .mod_cnt (mod_cnt)
);

// File: tb/rti_timer_tb_top.sv
`timescale 1ns/1ps
module rti_timer_tb_top;

    localparam logic [5:0] A_CTL = 6'h3B;
    localparam logic [5:0] A_FLG = 6'h37;
    localparam logic [5:0] A_EN  = 6'h38;
    localparam int MAX_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = A_FLG;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 1'b0;

    // Behavioural reference state
    logic [6:0] m_ctl;
    logic       m_flag;
    logic       m_en;
    int         m_cnt;

    always #4 clk = ~clk;

    rti_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int period_of(input logic [6:0] c);
        return (int'(c[3:0]) + 1) << (int'(c[6:4]) + 9);
    endfunction

    function automatic logic [7:0] model_rd(input logic [5:0] a);
        if (a == A_CTL) return {1'b0, m_ctl};
        if (a == A_FLG) return {7'b0, m_flag};
        if (a == A_EN)  return {7'b0, m_en};
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model: one integer counter over the whole period
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctl  = '0;
            m_flag = 1'b0;
            m_en   = 1'b0;
            m_cnt  = 0;
        end else begin
            bit hit;
            hit = 1'b0;
            if (bus_we && bus_addr == A_CTL) begin
                m_ctl = bus_wdata[6:0];
                m_cnt = 0;
            end else if (m_ctl[6:4] != 3'd0) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == period_of(m_ctl)) begin
                    hit   = 1'b1;
                    m_cnt = 0;
                end
            end
            if (bus_we && bus_addr == A_EN) m_en = bus_wdata[0];
            if (hit) m_flag = 1'b1;
            else if (bus_we && bus_addr == A_FLG && bus_wdata[0]) m_flag = 1'b0;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            check(irq === (m_flag & m_en), "R6 irq", int'(irq), int'(m_flag & m_en));
            check(bus_rdata === model_rd(bus_addr), "R1/R4/R10 rdata",
                  int'(bus_rdata), int'(model_rd(bus_addr)));
            if (cyc > MAX_CYC) begin
                check(1'b0, "watchdog", cyc, MAX_CYC);
                finish_run();
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = A_FLG; bus_wdata = '0;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata === exp, tag, int'(bus_rdata), int'(exp));
        #1 bus_addr = A_FLG;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write the control value and count cycles until irq rises (enable must be 1)
    task automatic measure(input logic [7:0] v, input string tag);
        int exp;
        int k;
        exp = (int'(v[3:0]) + 1) << (int'(v[6:4]) + 9);
        wr(A_CTL, v);
        k = 1;
        while (!irq && k < exp + 8) begin
            @(negedge clk);
            if (!irq) k++;
        end
        check(k == exp, tag, k, exp);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R7: reset state
        rd_check(A_CTL, 8'h00, "R7 ctl reset");
        rd_check(A_FLG, 8'h00, "R7 flag reset");
        rd_check(A_EN,  8'h00, "R7 en reset");

        // R1: bit 7 reserved; R10: unmapped address
        wr(A_CTL, 8'hFF);
        rd_check(A_CTL, 8'h7F, "R1 bit7 reads 0");
        rd_check(6'h00, 8'h00, "R10 unmapped");
        wr(A_CTL, 8'h00);
        wr(A_EN, 8'hFF);
        rd_check(A_EN, 8'h01, "R10 en upper bits");

        // R2: exact periods
        measure(8'h10, "R2 code1 N0");
        rd_check(A_FLG, 8'h01, "R2 flag set");
        wr(A_FLG, 8'h00);
        rd_check(A_FLG, 8'h01, "R4 write 0 no effect");
        wr(A_FLG, 8'h01);
        rd_check(A_FLG, 8'h00, "R4 W1C");
        // R9: next event without a control write
        begin
            int k = 0;
            while (!irq && k < 2000) begin @(negedge clk); k++; end
            check(irq === 1'b1, "R9 periodic repeat", int'(irq), 1);
        end
        wr(A_FLG, 8'h01);
        measure(8'h12, "R2 code1 N2");
        wr(A_FLG, 8'h01);
        measure(8'h21, "R2 code2 N1");
        wr(A_FLG, 8'h01);
        measure(8'h1F, "R2 code1 N15");
        wr(A_FLG, 8'h01);

        // R5: rewrite of the same value mid-period restarts the count
        wr(A_CTL, 8'h21);
        idle(2500);
        begin
            int k = 1;
            wr(A_CTL, 8'h21);
            while (!irq && k < 5000) begin @(negedge clk); if (!irq) k++; end
            check(k == 4096, "R5 same-value restart", k, 4096);
        end
        wr(A_FLG, 8'h01);

        // R3: code 0 with nonzero N never flags
        wr(A_CTL, 8'h09);
        idle(9000);
        rd_check(A_FLG, 8'h00, "R3 code0 silent");

        // R8: clear lands on the terminal cycle
        wr(A_CTL, 8'h10);
        while (m_cnt != 1023) @(negedge clk);
        #1; bus_we = 1'b1; bus_addr = A_FLG; bus_wdata = 8'h01;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        rd_check(A_FLG, 8'h01, "R8 set wins over clear");
        wr(A_FLG, 8'h01);

        // R6: flag sets while masked
        wr(A_EN, 8'h00);
        wr(A_CTL, 8'h10);
        idle(1100);
        rd_check(A_FLG, 8'h01, "R6 flag sets while masked");
        check(irq === 1'b0, "R6 irq masked", int'(irq), 0);
        wr(A_EN, 8'h01);
        @(negedge clk);
        check(irq === 1'b1, "R6 irq unmasked", int'(irq), 1);
        wr(A_FLG, 8'h01);

        // R2: longest prescale
        measure(8'h70, "R2 code7 N0");
        wr(A_CTL, 8'h00);
        idle(4);
        finish_run();
    end

endmodule